// File: doc/BRIEF.md
# Pruned 8-Bit Prefix Adder

This block adds two 8-bit unsigned operands and a carry input in pure combinational logic, producing an 8-bit sum and a carry output. The carries come from a logarithmic prefix network. A bitwise stage first forms a generate term (both operand bits set) and a propagate term (operand bits differ). Three combining levels then build the group generate for every span that ends at bit 0. A final stage XORs each propagate bit with the carry entering that position.

The network follows a Kogge-Stone arrangement, with the intermediate nodes that no final result needs left out. In the middle level, the span nodes 5:2 and 4:1 are not built. The level-3 nodes that would have used them take two shorter spans that meet exactly: 4:3 with 2:0, and 5:4 with 3:0. The node for span 2:1 is also dropped, so 2:0 is formed from bit 2 alone joined with 1:0. The carry input enters as an extra generate ahead of bit 0, so every span down to bit 0 already includes it.

The block is meant to sit inside a wider combinational datapath. No output is registered.

Top module: `pp_adder8`

## Requirements
- R1: With carry_in low and no bit position where both operands are 1, sum_out equals op_a OR op_b and carry_out is 0.
- R2: sum_out equals bits 7..0 of op_a + op_b + carry_in for every input combination.
- R3: carry_out equals bit 8 of op_a + op_b + carry_in for every input combination.
- R4: When op_a and op_b have no 1 in the same position, their OR is all ones, and carry_in is 1, the carry travels the full width: sum_out is 0x00 and carry_out is 1.
- R5: Sum bit i depends only on operand bits i..0 and carry_in. Changing any operand bit above i leaves sum_out[i] unchanged.
- R6: carry_out is 1 whenever op_a[7] and op_b[7] are both 1, whatever the other inputs are.
- R7: With both operands zero, sum_out equals carry_in in bit 0, is zero in all other bits, and carry_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 8 | Low 8 bits of the sum |
| carry_out | output | 1 | Carry out of bit 7 |

## Verification
The hardest case to reach is a carry that starts at carry_in or bit 0 and must cross the level-3 joins that replaced the removed nodes. Only a few specific operand patterns send a carry through the 4:3 + 2:0 or 5:4 + 3:0 joins. A random sweep seldom produces them. The bench therefore walks all 2^17 combinations of op_a, op_b and carry_in, so every propagate run of every length and starting point is covered. It then flips operand bits above each sum position to show that no higher span leaks into a lower carry.

// File: rtl/pp_adder_pkg.sv
package pp_adder_pkg;
    localparam int ADD_W  = 8;
    localparam int LEVELS = $clog2(ADD_W);

    typedef struct packed {
        logic g;
        logic p;
    } pg_t;

    // Join a higher span with the adjacent lower span
    function automatic pg_t pg_join(input pg_t hi, input pg_t lo);
        pg_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction
endpackage

// File: rtl/pp_pre.sv
module pp_pre
    import pp_adder_pkg::*;
(
    input  logic a,
    input  logic b,
    output pg_t  pg
);
    assign pg.g = a & b;
    assign pg.p = a ^ b;
endmodule

// File: rtl/pp_black.sv
module pp_black
    import pp_adder_pkg::*;
(
    input  pg_t hi,
    input  pg_t lo,
    output pg_t y
);
    assign y = pg_join(hi, lo);
endmodule

// File: rtl/pp_gray.sv
module pp_gray
    import pp_adder_pkg::*;
(
    input  pg_t  hi,
    input  logic lo_g,
    output logic g
);
    pg_t j;
    assign j = pg_join(hi, '{g: lo_g, p: 1'b0});
    assign g = j.g;
endmodule

// File: rtl/pp_buf.sv
module pp_buf #(
    parameter int W = 1
) (
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    assign q = d;
endmodule

// File: rtl/pp_adder8.sv
module pp_adder8
    import pp_adder_pkg::*;
(
    input  logic [ADD_W-1:0] op_a,
    input  logic [ADD_W-1:0] op_b,
    input  logic             carry_in,
    output logic [ADD_W-1:0] sum_out,
    output logic             carry_out
);
    localparam int HALF = ADD_W / 2;

    // bitwise stage
    logic [ADD_W-1:0] g0, p0;
    logic             g0f;     // bit 0 generate with carry_in folded in

    // level outputs: generate everywhere, propagate only where a later cell reads it
    logic [ADD_W-1:0] g1, g2, g3;
    logic [ADD_W-1:2] p1;
    logic [ADD_W-1:4] p2;

    generate
        for (genvar i = 0; i < ADD_W; i++) begin : g_pre
            pg_t pg;
            pp_pre u_pre (.a(op_a[i]), .b(op_b[i]), .pg(pg));
            assign g0[i] = pg.g;
            assign p0[i] = pg.p;
        end
    endgenerate

    pp_gray u_fold (.hi('{g: g0[0], p: p0[0]}), .lo_g(carry_in), .g(g0f));

    // level 1: distance 1
    generate
        for (genvar i = 0; i < ADD_W; i++) begin : g_l1
            if (i == 0) begin : g_b
                pp_buf #(.W(1)) u_b (.d(g0f), .q(g1[0]));
            end else if (i == 1) begin : g_g
                pp_gray u_g (.hi('{g: g0[1], p: p0[1]}), .lo_g(g0f), .g(g1[1]));
            end else if (i == 2) begin : g_b2
                // span 2:1 is never consumed; bit 2 passes through alone
                pp_buf #(.W(2)) u_b (.d({g0[2], p0[2]}), .q({g1[2], p1[2]}));
            end else begin : g_k
                pg_t y;
                pp_black u_k (.hi('{g: g0[i], p: p0[i]}),
                              .lo('{g: g0[i-1], p: p0[i-1]}), .y(y));
                assign g1[i] = y.g;
                assign p1[i] = y.p;
            end
        end
    endgenerate

    // level 2: distance 2, spans 5:2 and 4:1 pruned
    generate
        for (genvar i = 0; i < ADD_W; i++) begin : g_l2
            if (i < 2) begin : g_b
                pp_buf #(.W(1)) u_b (.d(g1[i]), .q(g2[i]));
            end else if (i < HALF) begin : g_g
                // 2:0 and 3:0 both take their low input from 1:0
                pp_gray u_g (.hi('{g: g1[i], p: p1[i]}), .lo_g(g1[1]), .g(g2[i]));
            end else if (i < HALF + 2) begin : g_bp
                pp_buf #(.W(2)) u_b (.d({g1[i], p1[i]}), .q({g2[i], p2[i]}));
            end else begin : g_k
                pg_t y;
                pp_black u_k (.hi('{g: g1[i], p: p1[i]}),
                              .lo('{g: g1[i-2], p: p1[i-2]}), .y(y));
                assign g2[i] = y.g;
                assign p2[i] = y.p;
            end
        end
    endgenerate

    // level 3: every upper span joins 2:0 (even bits) or 3:0 (odd bits)
    generate
        for (genvar i = 0; i < ADD_W; i++) begin : g_l3
            if (i < HALF) begin : g_b
                pp_buf #(.W(1)) u_b (.d(g2[i]), .q(g3[i]));
            end else begin : g_g
                pp_gray u_g (.hi('{g: g2[i], p: p2[i]}),
                             .lo_g(g2[2 + (i % 2)]), .g(g3[i]));
            end
        end
    endgenerate

    // sum stage
    assign sum_out   = p0 ^ {g3[ADD_W-2:0], carry_in};
    assign carry_out = g3[ADD_W-1];
endmodule

// File: rtl/pp_adder8_chk.sv
module pp_adder8_chk
    import pp_adder_pkg::*;
(
    input logic [ADD_W-1:0] op_a,
    input logic [ADD_W-1:0] op_b,
    input logic             carry_in,
    input logic [ADD_W-1:0] sum_out,
    input logic             carry_out
);
    logic [ADD_W:0] ref_sum;
    assign ref_sum = {1'b0, op_a} + {1'b0, op_b} + {{ADD_W{1'b0}}, carry_in};

    always_comb begin
        p_sum_value_r2: assert (sum_out == ref_sum[ADD_W-1:0])
            else $error("sum mismatch");
        p_carry_value_r3: assert (carry_out == ref_sum[ADD_W])
            else $error("carry mismatch");
        p_msb_pair_r6: assert (!(op_a[ADD_W-1] && op_b[ADD_W-1]) || carry_out)
            else $error("msb pair without carry");
        p_no_carry_r1: assert (!(((op_a & op_b) == '0) && !carry_in)
                               || ((sum_out == (op_a | op_b)) && !carry_out))
            else $error("carry appeared with no generate");
        p_full_ripple_r4: assert (!(((op_a & op_b) == '0) && ((op_a | op_b) == '1) && carry_in)
                                  || ((sum_out == '0) && carry_out))
            else $error("full-width ripple lost");
    end
endmodule

bind pp_adder8 pp_adder8_chk i_chk (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sum_out(sum_out), .carry_out(carry_out)
);

// File: tb/test_pp_adder8.sv
module test_pp_adder8;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] a, b;
    logic       ci;
    logic [7:0] s;
    logic       co;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pp_adder8 i_pp_adder8 (.op_a(a), .op_b(b), .carry_in(ci), .sum_out(s), .carry_out(co));

    task automatic apply(input logic [7:0] xa, input logic [7:0] xb, input logic xc);
        @(negedge clk);
        a = xa; b = xb; ci = xc;
        @(posedge clk);
    endtask

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s a=%h b=%h ci=%b actual=%h expected=%h", req, a, b, ci, act, exp);
        end
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; ci = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R7: zero operands
        apply(8'h00, 8'h00, 1'b0);
        chk("R7", {co, s}, 9'h000);
        apply(8'h00, 8'h00, 1'b1);
        chk("R7", {co, s}, 9'h001);

        // R4: full-width ripple from carry_in
        apply(8'hFF, 8'h00, 1'b1);
        chk("R4", {co, s}, 9'h100);
        apply(8'hA5, 8'h5A, 1'b1);
        chk("R4", {co, s}, 9'h100);

        // R6: both msbs set
        apply(8'h80, 8'h80, 1'b0);
        chk("R6", {8'h00, co}, 9'h001);

        // R1: disjoint operands, no carry_in
        apply(8'hF0, 8'h0F, 1'b0);
        chk("R1", {co, s}, 9'h0FF);
        apply(8'h24, 8'h41, 1'b0);
        chk("R1", {co, s}, 9'h065);

        // R2, R3: exhaustive sweep
        for (int c = 0; c < 2; c++) begin
            for (int x = 0; x < 256; x++) begin
                for (int y = 0; y < 256; y++) begin
                    logic [8:0] e;
                    e = 9'(x) + 9'(y) + 9'(c);
                    apply(8'(x), 8'(y), 1'(c));
                    chk("R2", {1'b0, s}, {1'b0, e[7:0]});
                    chk("R3", {8'h00, co}, {8'h00, e[8]});
                end
            end
        end

        // R5: bits above i do not disturb sum bit i
        for (int i = 0; i < 7; i++) begin
            for (int c = 0; c < 2; c++) begin
                logic [7:0] base_a, base_b, hi_m;
                logic       ref_bit;
                base_a = 8'h5B >> (7 - i);
                base_b = 8'hFF >> (7 - i);
                hi_m   = 8'hFF << (i + 1);
                apply(base_a, base_b, 1'(c));
                ref_bit = s[i];
                apply(base_a | hi_m, base_b, 1'(c));
                chk("R5", {8'h00, s[i]}, {8'h00, ref_bit});
                apply(base_a, base_b | (hi_m & 8'hA5), 1'(c));
                chk("R5", {8'h00, s[i]}, {8'h00, ref_bit});
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule